// File: doc/BRIEF.md
# Step-Down Converter Real-Time Plant Model

This block is a real-time model of a step-down switching converter for hardware-in-the-loop testing of a converter controller. Each rising clock edge is one simulation step. At each step the model advances two state variables by explicit Euler integration: the inductor current and the capacitor voltage. The controller under test drives the two switch gates. These gates are synchronised inside the block. The input voltage and load current come in as plain signed integers.

All arithmetic uses signed integers. The binary-point position of each quantity is set by a right-shift count loaded at run time. Before a run, the host works out two sets of values from the expected maxima and the component values: the step-over-inductance and step-over-capacitance constants, and four shift counts. The host writes these through a small write port while the run enable is low. The same netlist then covers very different voltage, current and component ranges.

The two state updates are not pipelined. They feed each other directly through reduced-precision copies of the state variables. The accumulators saturate at the signed limits instead of wrapping, and a sticky flag records that saturation has occurred.

Top module: `buck_plant_model`

## Requirements
- R1: While `run_en` is low at a rising edge, the next values of `il_out`, `vc_out` and `ovf_flag` are all zero.
- R2: While `run_en` is low, a rising edge with `cfg_we` high stores `cfg_wdata` into the field selected by `cfg_addr`. The fields are: 0 = current gain KL (18-bit signed), 1 = voltage gain KC (18-bit signed), 2 = current increment shift SI (low 6 bits), 3 = voltage increment shift SV (low 6 bits), 4 = current feedback shift FI (low 6 bits), 5 = voltage feedback shift FV (low 6 bits). While `run_en` is high, writes are ignored.
- R3: Each gate input passes through two synchronising flip-flops. A gate level applied before rising edge e1 first governs the state update made at edge e3.
- R4: When the high-side gate is on (synchronised), the update is IL += (KL·(vin − (VC>>>FV)))>>>SI and VC += (KC·((IL>>>FI) − iload))>>>SV. All right shifts are arithmetic, and both updates use the values from before the step.
- R5: When only the low-side gate is on, the current update uses a drive of −(VC>>>FV). The voltage update is the same as in R4.
- R6: When both gates are on, the high-side equations of R4 apply.
- R7: When both gates are off and IL > 0, the low-side equations apply. When both gates are off and IL < 0, the high-side equations apply.
- R8: When both gates are off and IL is exactly zero, IL stays at zero and VC still updates as in R4.
- R9: An update that would leave the 28-bit signed range is clamped to +2^27−1 or −2^27.
- R10: `ovf_flag` goes high on the step after a clamp and stays high until `run_en` goes low.
- R11: Both state variables change on every step. A new input value affects the state at the next edge, with no added pipeline delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Step clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | High to integrate; low holds the state at zero and opens the config port |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | 3 | Config field select (see R2) |
| cfg_wdata | input | 18 | Config write data |
| gate_hi | input | 1 | High-side switch gate, asynchronous |
| gate_lo | input | 1 | Low-side switch gate, asynchronous |
| vin | input | 28 | Input voltage at the voltage feedback scale |
| iload | input | 28 | Load current at the current feedback scale |
| il_out | output | 28 | Inductor current state |
| vc_out | output | 28 | Capacitor voltage state |
| ovf_flag | output | 1 | Sticky saturation flag |

## Verification
The assertions assume three things about the inputs. First, `run_en` and the config port change only between edges. Second, the config fields are written only while `run_en` is low; the frozen-configuration property relies on this. Third, the gate levels may change at any time, since only their synchronised copies are checked. The stimulus follows these rules: it drives every input at the falling edge and writes configuration only with `run_en` low, except for one deliberate write during a run. That write tests that the block ignores it. The stimulus also picks gains, shifts and input levels so that dead-time cases with positive, negative and exactly zero current actually occur, and so that one scenario drives each accumulator into its positive or negative clamp.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
    localparam int unsigned STATE_W = 28;
    localparam int unsigned GAIN_W  = 18;
    localparam int unsigned SHIFT_W = 6;

    typedef enum logic [2:0] {
        CFG_K_L   = 3'd0,
        CFG_K_C   = 3'd1,
        CFG_SH_IL = 3'd2,
        CFG_SH_VC = 3'd3,
        CFG_SH_IF = 3'd4,
        CFG_SH_VF = 3'd5
    } cfg_sel_e;
endpackage

// File: rtl/bpm_sync2.sv
module bpm_sync2 #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/bpm_scale_shift.sv
module bpm_scale_shift #(
    parameter int unsigned W   = 28,
    parameter int unsigned SHW = 6
) (
    input  logic signed [W-1:0]   din,
    input  logic        [SHW-1:0] sh,
    output logic signed [W-1:0]   dout
);
    logic signed [W-1:0] stg [0:SHW];

    assign stg[0] = din;

    for (genvar i = 0; i < SHW; i++) begin : g_stage
        assign stg[i+1] = sh[i] ? (stg[i] >>> (2**i)) : stg[i];
    end

    assign dout = stg[SHW];
endmodule

// File: rtl/bpm_euler.sv
module bpm_euler #(
    parameter int unsigned W   = 28,
    parameter int unsigned CW  = 18,
    parameter int unsigned SHW = 6
) (
    input  logic signed [W-1:0]   acc,
    input  logic signed [CW-1:0]  gain,
    input  logic signed [W:0]     drive,
    input  logic        [SHW-1:0] sh,
    input  logic                  hold,
    output logic signed [W-1:0]   nxt,
    output logic                  sat
);
    localparam int unsigned PW   = CW + W + 1;
    localparam int unsigned SUMW = PW + 1;
    localparam logic signed [SUMW-1:0] HI =
        $signed({{(SUMW-W+1){1'b0}}, {(W-1){1'b1}}});
    localparam logic signed [SUMW-1:0] LO = -HI - 1;

    logic signed [PW-1:0]   prod;
    logic signed [PW-1:0]   inc;
    logic signed [SUMW-1:0] sum;

    always_comb begin
        prod = PW'(gain) * PW'(drive);
        inc  = prod >>> sh;
        sum  = SUMW'(acc) + SUMW'(inc);
        sat  = 1'b0;
        if (hold) begin
            nxt = acc;
        end else if (sum > HI) begin
            nxt = HI[W-1:0];
            sat = 1'b1;
        end else if (sum < LO) begin
            nxt = LO[W-1:0];
            sat = 1'b1;
        end else begin
            nxt = sum[W-1:0];
        end
    end
endmodule

// File: rtl/buck_plant_model.sv
module buck_plant_model #(
    parameter int unsigned W   = bpm_pkg::STATE_W,
    parameter int unsigned CW  = bpm_pkg::GAIN_W,
    parameter int unsigned SHW = bpm_pkg::SHIFT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_en,
    input  logic                 cfg_we,
    input  logic [2:0]           cfg_addr,
    input  logic [CW-1:0]        cfg_wdata,
    input  logic                 gate_hi,
    input  logic                 gate_lo,
    input  logic signed [W-1:0]  vin,
    input  logic signed [W-1:0]  iload,
    output logic signed [W-1:0]  il_out,
    output logic signed [W-1:0]  vc_out,
    output logic                 ovf_flag
);
    import bpm_pkg::*;

    typedef struct packed {
        logic signed [W-1:0]  il;
        logic signed [W-1:0]  vc;
        logic                 ovf;
        logic signed [CW-1:0] k_l;
        logic signed [CW-1:0] k_c;
        logic [SHW-1:0]       sh_il;
        logic [SHW-1:0]       sh_vc;
        logic [SHW-1:0]       sh_if;
        logic [SHW-1:0]       sh_vf;
    } plant_t;

    plant_t st_d, st_q;

    logic [1:0]          gate_s;
    logic                gate_hi_s, gate_lo_s;
    logic signed [W-1:0] il_fb, vc_fb;
    logic signed [W:0]   v_ind, i_cap;
    logic                use_hi, hold_il;
    logic signed [W-1:0] il_nxt, vc_nxt;
    logic                il_sat, vc_sat;
    logic signed [CW-1:0] k_l_w, k_c_w;

    bpm_sync2 #(.N(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({gate_hi, gate_lo}),
        .dout (gate_s)
    );
    assign gate_hi_s = gate_s[1];
    assign gate_lo_s = gate_s[0];

    bpm_scale_shift #(.W(W), .SHW(SHW)) u_fb_il (
        .din(st_q.il), .sh(st_q.sh_if), .dout(il_fb)
    );
    bpm_scale_shift #(.W(W), .SHW(SHW)) u_fb_vc (
        .din(st_q.vc), .sh(st_q.sh_vf), .dout(vc_fb)
    );

    // switch-state decode: high side wins, dead time follows current sign
    always_comb begin
        hold_il = 1'b0;
        if (gate_hi_s) begin
            use_hi = 1'b1;
        end else if (gate_lo_s) begin
            use_hi = 1'b0;
        end else begin
            use_hi  = st_q.il[W-1];
            hold_il = (st_q.il == '0);
        end
        v_ind = use_hi ? ((W+1)'(vin) - (W+1)'(vc_fb)) : -((W+1)'(vc_fb));
        i_cap = (W+1)'(il_fb) - (W+1)'(iload);
    end

    assign k_l_w = st_q.k_l;
    assign k_c_w = st_q.k_c;

    bpm_euler #(.W(W), .CW(CW), .SHW(SHW)) u_int_il (
        .acc(st_q.il), .gain(k_l_w), .drive(v_ind), .sh(st_q.sh_il),
        .hold(hold_il), .nxt(il_nxt), .sat(il_sat)
    );
    bpm_euler #(.W(W), .CW(CW), .SHW(SHW)) u_int_vc (
        .acc(st_q.vc), .gain(k_c_w), .drive(i_cap), .sh(st_q.sh_vc),
        .hold(1'b0), .nxt(vc_nxt), .sat(vc_sat)
    );

    always_comb begin
        st_d = st_q;
        if (!run_en) begin
            st_d.il  = '0;
            st_d.vc  = '0;
            st_d.ovf = 1'b0;
            if (cfg_we) begin
                case (cfg_addr)
                    CFG_K_L:   st_d.k_l   = cfg_wdata;
                    CFG_K_C:   st_d.k_c   = cfg_wdata;
                    CFG_SH_IL: st_d.sh_il = cfg_wdata[SHW-1:0];
                    CFG_SH_VC: st_d.sh_vc = cfg_wdata[SHW-1:0];
                    CFG_SH_IF: st_d.sh_if = cfg_wdata[SHW-1:0];
                    CFG_SH_VF: st_d.sh_vf = cfg_wdata[SHW-1:0];
                    default: ;
                endcase
            end
        end else begin
            st_d.il  = il_nxt;
            st_d.vc  = vc_nxt;
            st_d.ovf = st_q.ovf | il_sat | vc_sat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign il_out   = st_q.il;
    assign vc_out   = st_q.vc;
    assign ovf_flag = st_q.ovf;
endmodule

// File: rtl/bpm_checker.sv
module bpm_checker #(
    parameter int unsigned W  = 28,
    parameter int unsigned CW = 18
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 run_en,
    input logic                 gh_s,
    input logic                 gl_s,
    input logic signed [W-1:0]  il,
    input logic signed [W-1:0]  vc,
    input logic                 ovf,
    input logic signed [CW-1:0] k_l,
    input logic signed [CW-1:0] k_c
);
    localparam logic signed [W-1:0] SMAX = $signed({1'b0, {(W-1){1'b1}}});
    localparam logic signed [W-1:0] SMIN = $signed({1'b1, {(W-1){1'b0}}});

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (il == '0 && vc == '0 && !ovf)); // R1

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && $past(run_en)) |-> ($stable(k_l) && $stable(k_c))); // R2

    AST_DEAD_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !gh_s && !gl_s && il == '0) |=> (il == '0)); // R8

    AST_CLAMP_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> (il == SMAX || il == SMIN || vc == SMAX || vc == SMIN)); // R9

    AST_NO_OVERFLOW_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && ovf) |=> ovf); // R10
endmodule

bind buck_plant_model bpm_checker #(.W(W), .CW(CW)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .run_en(run_en),
    .gh_s  (gate_hi_s),
    .gl_s  (gate_lo_s),
    .il    (il_out),
    .vc    (vc_out),
    .ovf   (ovf_flag),
    .k_l   (k_l_w),
    .k_c   (k_c_w)
);

// File: tb/sim_buck_plant_model.sv
module sim_buck_plant_model;
    localparam time CLK_PERIOD = 10ns;
    localparam int  W = 28;
    localparam longint SMAX = (64'sd1 <<< (W-1)) - 1;
    localparam longint SMIN = -(64'sd1 <<< (W-1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [17:0] cfg_wdata = '0;
    logic gate_hi = 1'b0;
    logic gate_lo = 1'b0;
    logic signed [W-1:0] vin = '0;
    logic signed [W-1:0] iload = '0;
    logic signed [W-1:0] il_out, vc_out;
    logic ovf_flag;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // bench reference state
    longint r_il = 0, r_vc = 0;
    bit     r_ovf = 0;
    longint r_kl = 0, r_kc = 0;
    int     r_si = 0, r_sv = 0, r_fi = 0, r_fv = 0;
    bit [1:0] r_s1 = 0, r_s2 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    buck_plant_model u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .gate_hi(gate_hi),
        .gate_lo(gate_lo), .vin(vin), .iload(iload), .il_out(il_out),
        .vc_out(vc_out), .ovf_flag(ovf_flag)
    );

    function automatic longint clamp(input longint v, output bit hit);
        hit = 1'b0;
        if (v > SMAX) begin hit = 1'b1; return SMAX; end
        if (v < SMIN) begin hit = 1'b1; return SMIN; end
        return v;
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one step of the bench model, then compare at the falling edge
    task automatic step(input string req);
        longint vcf, ilf, vl, ic, nil, nvc;
        bit hi, hold, h1, h2;
        @(posedge clk);
        if (!run_en) begin
            r_il = 0; r_vc = 0; r_ovf = 0;
            if (cfg_we) begin
                case (cfg_addr)
                    3'd0: r_kl = longint'($signed(cfg_wdata));
                    3'd1: r_kc = longint'($signed(cfg_wdata));
                    3'd2: r_si = int'(cfg_wdata[5:0]);
                    3'd3: r_sv = int'(cfg_wdata[5:0]);
                    3'd4: r_fi = int'(cfg_wdata[5:0]);
                    3'd5: r_fv = int'(cfg_wdata[5:0]);
                    default: ;
                endcase
            end
        end else begin
            vcf = r_vc >>> r_fv;
            ilf = r_il >>> r_fi;
            hold = 0;
            if (r_s2[1]) hi = 1;
            else if (r_s2[0]) hi = 0;
            else begin hi = (r_il < 0); hold = (r_il == 0); end
            vl = hi ? (longint'(vin) - vcf) : -vcf;
            ic = ilf - longint'(iload);
            nil = hold ? r_il : clamp(r_il + ((r_kl * vl) >>> r_si), h1);
            if (hold) h1 = 0;
            nvc = clamp(r_vc + ((r_kc * ic) >>> r_sv), h2);
            r_il = nil; r_vc = nvc; r_ovf = r_ovf | h1 | h2;
        end
        r_s2 = r_s1;
        r_s1 = {gate_hi, gate_lo};
        @(negedge clk);
        check(req, "il_out", longint'(il_out), r_il);
        check(req, "vc_out", longint'(vc_out), r_vc);
        check(req, "ovf_flag", longint'(ovf_flag), longint'(r_ovf));
    endtask

    task automatic cfg_write(input bit [2:0] a, input logic [17:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step("R2");
        cfg_we = 1'b0;
    endtask

    task automatic setup(input int kl, input int kc, input int si, input int sv, input int fi, input int fv);
        run_en = 1'b0; gate_hi = 0; gate_lo = 0;
        cfg_write(3'd0, 18'(kl));
        cfg_write(3'd1, 18'(kc));
        cfg_write(3'd2, 18'(si));
        cfg_write(3'd3, 18'(sv));
        cfg_write(3'd4, 18'(fi));
        cfg_write(3'd5, 18'(fv));
        step("R1");
    endtask

    task automatic t_reset();
        check("R1", "il_out in reset", longint'(il_out), 0);
        check("R1", "vc_out in reset", longint'(vc_out), 0);
        check("R1", "ovf_flag in reset", longint'(ovf_flag), 0);
    endtask

    task automatic t_latency();
        setup(1000, 500, 4, 6, 8, 8);
        vin = 28'sd10000; iload = '0;
        run_en = 1'b1;
        for (int i = 0; i < 4; i++) step("R8");
        gate_hi = 1'b1;
        step("R3"); check("R3", "il after e1", longint'(il_out), 0);
        step("R3"); check("R3", "il after e2", longint'(il_out), 0);
        step("R3"); check("R3", "il after e3", longint'(il_out), (1000 * 10000) >>> 4);
    endtask

    task automatic t_high_low_dead();
        for (int i = 0; i < 17; i++) step("R4");
        gate_hi = 0; gate_lo = 1;
        for (int i = 0; i < 6; i++) step("R5");
        gate_lo = 0;
        check("R7", "positive current before dead time", longint'(r_il > 0), 1);
        for (int i = 0; i < 4; i++) step("R7");
        gate_lo = 1;
        for (int i = 0; i < 500 && r_il >= 0; i++) step("R5");
        for (int i = 0; i < 2; i++) step("R5");
        gate_lo = 0;
        check("R7", "negative current before dead time", longint'(r_il < 0), 1);
        for (int i = 0; i < 4; i++) step("R7");
    endtask

    task automatic t_both_on();
        setup(800, 300, 5, 6, 8, 8);
        vin = 28'sd20000; iload = 28'sd1000;
        gate_lo = 1; run_en = 1'b1;
        for (int i = 0; i < 8; i++) step("R5");
        gate_hi = 1;
        for (int i = 0; i < 8; i++) step("R6");
        gate_hi = 0; gate_lo = 0;
    endtask

    task automatic t_dead_zero();
        setup(1000, 700, 4, 5, 8, 8);
        vin = 28'sd50000; iload = 28'sd5000;
        run_en = 1'b1;
        for (int i = 0; i < 6; i++) begin
            step("R8");
            check("R8", "il held at zero", longint'(il_out), 0);
        end
        check("R8", "vc moved", longint'(vc_out != 0), 1);
    endtask

    task automatic t_frozen_cfg();
        setup(1000, 500, 4, 6, 8, 8);
        vin = 28'sd10000; iload = '0; gate_hi = 1; run_en = 1'b1;
        for (int i = 0; i < 4; i++) step("R11");
        cfg_write(3'd0, 18'sd100000);
        cfg_write(3'd2, 18'd0);
        for (int i = 0; i < 4; i++) step("R2");
        gate_hi = 0;
    endtask

    task automatic t_saturate();
        setup(131071, 1000, 0, 6, 8, 8);
        vin = 28'sd134217727; iload = '0; gate_hi = 1; run_en = 1'b1;
        for (int i = 0; i < 4; i++) step("R9");
        check("R9", "il at upper clamp", longint'(il_out), SMAX);
        check("R10", "flag set", longint'(ovf_flag), 1);
        gate_hi = 0; gate_lo = 1;
        for (int i = 0; i < 6; i++) step("R10");
        check("R10", "flag still set", longint'(ovf_flag), 1);
        gate_lo = 0;
        setup(131071, 1000, 0, 6, 8, 8);
        vin = -28'sd134217728; gate_hi = 1; run_en = 1'b1;
        for (int i = 0; i < 4; i++) step("R9");
        check("R9", "il at lower clamp", longint'(il_out), SMIN);
        gate_hi = 0; run_en = 1'b0;
        step("R10");
        check("R10", "flag cleared by run_en low", longint'(ovf_flag), 0);
        check("R1", "il cleared by run_en low", longint'(il_out), 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_latency();
        t_high_low_dead();
        t_both_on();
        t_dead_zero();
        t_frozen_cfg();
        t_saturate();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule